// File: doc/BRIEF.md
# Debug Pin Shell with Register Window

This block sits between a small 8-bit processor core and the package pins. On the core side it sees the core's bus address, write strobe, write data and a set of internal state values: the accumulator, the memory pointer, the program counter, the instruction register, the condition flags and the control-unit state. On the pin side it drives seven address pins, a write-strobe pin and the outgoing data byte, and it returns the incoming data byte to the core.

An 8-bit configuration input sets how the shell behaves. When the bank-enable bit is set, a bank of eight 8-bit scratch registers appears in the address window 0x78 to 0x7F. Reads in that window return a bank register instead of the external bus. Writes in that window land in the bank and are kept off the write-strobe pin. A 3-bit view selector can swap the address pins for one of the core's internal values, so that state can be watched on silicon. Two further configuration bits are passed through to the core: one enables the built-in demo program and one requests a halt. Every configuration bit is active high, and an all-zero configuration gives plain pass-through operation.

Top module: `dbg_shell`

## Requirements
- R1: While rst_ni is low, all eight bank registers hold zero. A read in the window with the bank enabled then returns 0x00.
- R2: With cfg_i[7]=1 and core_addr_i in 0x78..0x7F, core_rdata_o is the bank register at index core_addr_i[2:0], combinationally.
- R3: With cfg_i[7]=1 and a write strobe in the window, the indexed register takes core_wdata_i on the rising clock edge, and bus_we_o stays low.
- R4: With cfg_i[7]=0, window accesses pass through. core_rdata_o equals bus_rdata_i, bus_we_o equals core_we_i, and the bank contents do not change.
- R5: Addresses outside 0x78..0x7F always pass through, whatever cfg_i[7] is. This includes addresses with bit 7 set, such as 0xF8.
- R6: View select cfg_i[2:0] picks what bus_addr_o shows. Code 000 gives core_addr_i[6:0]. Code 001 gives acc_i[6:0]. Code 010 gives acc_i[7] on pin 0 with pins 6:1 at zero.
- R7: Codes 011, 100 and 101 give mptr_i[6:0], pc_i[6:0] and ir_i[6:0]. Code 110 gives ccr_i on pins 1:0 with pins 6:2 at zero. Code 111 gives cu_state_i.
- R8: demo_en_o follows cfg_i[4] and halt_req_o follows cfg_i[3]. cfg_i[6:5] has no effect on any output.
- R9: bus_wdata_o always equals core_wdata_i. The view selector never changes bus_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 8 | Configuration: [7] bank enable, [4] demo enable, [3] halt request, [2:0] view select |
| core_addr_i | input | 8 | Core bus address |
| core_we_i | input | 1 | Core write strobe |
| core_wdata_i | input | 8 | Core write data |
| core_rdata_o | output | 8 | Read data returned to the core |
| acc_i | input | 8 | Accumulator value |
| mptr_i | input | 8 | Memory pointer value |
| pc_i | input | 8 | Program counter value |
| ir_i | input | 8 | Instruction register value |
| ccr_i | input | 2 | Condition flags |
| cu_state_i | input | 7 | Control-unit state |
| bus_rdata_i | input | 8 | Data byte from the external bus |
| bus_addr_o | output | 7 | Address pins, or the selected debug view |
| bus_we_o | output | 1 | Write-strobe pin |
| bus_wdata_o | output | 8 | Data byte driven to the external bus |
| demo_en_o | output | 1 | Demo program enable to the core |
| halt_req_o | output | 1 | Halt request to the core |

## Verification
The hardest case to reach is a write made while the bank is disabled. Its effect, that the bank is left untouched, can only be seen after the bank is turned back on and the same address is read. The stimulus therefore fills all eight registers, turns cfg_i[7] off, writes to a window address, turns the bank back on and reads that address. A second hard case is 0xF8: its low seven bits match the window, but bit 7 is set. The bench drives it with the bank enabled and expects pass-through. Every clock, the reference model predicts the read data, the strobe pin and the address-pin view.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int CFG_BANK_EN = 7;
  localparam int CFG_DEMO_EN = 4;
  localparam int CFG_HALT    = 3;
  localparam int SEL_W       = 3;

  typedef enum logic [SEL_W-1:0] {
    VIEW_ADDR  = 3'd0,
    VIEW_ACC   = 3'd1,
    VIEW_MSB   = 3'd2,
    VIEW_MPTR  = 3'd3,
    VIEW_PC    = 3'd4,
    VIEW_IR    = 3'd5,
    VIEW_CCR   = 3'd6,
    VIEW_STATE = 3'd7
  } view_sel_e;
endpackage

// File: rtl/gpr_window.sv
module gpr_window #(
  parameter int          DW   = 8,
  parameter int          AW   = 8,
  parameter int          NREG = 8,
  parameter logic [AW-1:0] BASE = 8'h78
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          hit_o,
  output logic [DW-1:0] rdata_o
);
  localparam int IDXW = $clog2(NREG);

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [IDXW-1:0]         idx;
  logic                    unused_base;

  assign idx         = addr_i[IDXW-1:0];
  assign hit_o       = en_i && (addr_i[AW-1:IDXW] == BASE[AW-1:IDXW]);
  assign unused_base = ^BASE[IDXW-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= '0;
      else if (hit_o && we_i && (idx == IDXW'(g)))
        regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[idx];
endmodule

// File: rtl/dbg_view_mux.sv
module dbg_view_mux
  import dbg_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PW  = 7,
  parameter int CW  = 2,
  parameter int SW  = 7
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [PW-1:0]    addr_i,
  input  logic [DW-1:0]    acc_i,
  input  logic [DW-1:0]    mptr_i,
  input  logic [DW-1:0]    pc_i,
  input  logic [DW-1:0]    ir_i,
  input  logic [CW-1:0]    ccr_i,
  input  logic [SW-1:0]    state_i,
  output logic [PW-1:0]    pins_o
);
  logic unused_hi;
  assign unused_hi = ^{acc_i[DW-2:PW], mptr_i[DW-1:PW], pc_i[DW-1:PW], ir_i[DW-1:PW]};

  always_comb begin
    pins_o = '0;
    unique case (view_sel_e'(sel_i))
      VIEW_ADDR:  pins_o = addr_i;
      VIEW_ACC:   pins_o = acc_i[PW-1:0];
      VIEW_MSB:   pins_o[0] = acc_i[DW-1];
      VIEW_MPTR:  pins_o = mptr_i[PW-1:0];
      VIEW_PC:    pins_o = pc_i[PW-1:0];
      VIEW_IR:    pins_o = ir_i[PW-1:0];
      VIEW_CCR:   pins_o[CW-1:0] = ccr_i;
      VIEW_STATE: pins_o[SW-1:0] = state_i;
      default:    pins_o = '0;
    endcase
  end
endmodule

// File: rtl/dbg_shell.sv
module dbg_shell
  import dbg_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int PW = 7,
  parameter int CW = 2,
  parameter int SW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    cfg_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic          core_we_i,
  input  logic [DW-1:0] core_wdata_i,
  output logic [DW-1:0] core_rdata_o,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mptr_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] ir_i,
  input  logic [CW-1:0] ccr_i,
  input  logic [SW-1:0] cu_state_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [PW-1:0] bus_addr_o,
  output logic          bus_we_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          demo_en_o,
  output logic          halt_req_o
);
  logic          win_hit;
  logic [DW-1:0] win_rdata;
  logic          unused_cfg;

  assign unused_cfg = ^cfg_i[6:5];

  gpr_window #(.DW(DW), .AW(AW), .NREG(8), .BASE(AW'(8'h78))) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg_i[CFG_BANK_EN]),
    .addr_i  (core_addr_i),
    .we_i    (core_we_i),
    .wdata_i (core_wdata_i),
    .hit_o   (win_hit),
    .rdata_o (win_rdata)
  );

  dbg_view_mux #(.DW(DW), .PW(PW), .CW(CW), .SW(SW)) u_view (
    .sel_i   (cfg_i[SEL_W-1:0]),
    .addr_i  (core_addr_i[PW-1:0]),
    .acc_i   (acc_i),
    .mptr_i  (mptr_i),
    .pc_i    (pc_i),
    .ir_i    (ir_i),
    .ccr_i   (ccr_i),
    .state_i (cu_state_i),
    .pins_o  (bus_addr_o)
  );

  assign core_rdata_o = win_hit ? win_rdata : bus_rdata_i;
  assign bus_we_o     = core_we_i && !win_hit;
  assign bus_wdata_o  = core_wdata_i;
  assign demo_en_o    = cfg_i[CFG_DEMO_EN];
  assign halt_req_o   = cfg_i[CFG_HALT];
endmodule

module dbg_shell_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] cfg_i,
  input logic [7:0] core_addr_i,
  input logic       core_we_i,
  input logic [7:0] core_wdata_i,
  input logic [7:0] core_rdata_o,
  input logic [7:0] bus_rdata_i,
  input logic [6:0] bus_addr_o,
  input logic       bus_we_o
);
  logic in_win;
  assign in_win = cfg_i[7] && (core_addr_i >= 8'h78) && (core_addr_i <= 8'h7F);

  AST_WIN_WE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && core_we_i) |-> !bus_we_o); // R3

  AST_OUT_WIN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> (core_rdata_o == bus_rdata_i && bus_we_o == core_we_i)); // R4

  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && !core_we_i && $past(rst_ni) && $past(in_win && core_we_i)
      && core_addr_i == $past(core_addr_i))
    |-> core_rdata_o == $past(core_wdata_i)); // R2

  AST_ADDR_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[2:0] == 3'd0) |-> bus_addr_o == core_addr_i[6:0]); // R6

  AST_MSB_VIEW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[2:0] == 3'd2) |-> bus_addr_o[6:1] == 6'd0); // R6

  AST_CCR_VIEW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[2:0] == 3'd6) |-> bus_addr_o[6:2] == 5'd0); // R7
endmodule

bind dbg_shell dbg_shell_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_i        (cfg_i),
  .core_addr_i  (core_addr_i),
  .core_we_i    (core_we_i),
  .core_wdata_i (core_wdata_i),
  .core_rdata_o (core_rdata_o),
  .bus_rdata_i  (bus_rdata_i),
  .bus_addr_o   (bus_addr_o),
  .bus_we_o     (bus_we_o)
);

// File: tb/sim_dbg_shell.sv
`timescale 1ns/1ps
module sim_dbg_shell;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd_bus = 8'h00;
  logic [7:0] acc = 8'h00, mptr = 8'h00, pc = 8'h00, ir = 8'h00;
  logic [1:0] ccr = 2'b00;
  logic [6:0] st = 7'h00;
  logic [7:0] rdata_o;
  logic [6:0] addr_o;
  logic       we_o;
  logic [7:0] wdata_o;
  logic       demo_o, halt_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  int  model [8];

  always #(CLK_P/2) clk = ~clk;

  dbg_shell u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .core_addr_i(addr), .core_we_i(we),
    .core_wdata_i(wd), .core_rdata_o(rdata_o), .acc_i(acc), .mptr_i(mptr), .pc_i(pc),
    .ir_i(ir), .ccr_i(ccr), .cu_state_i(st), .bus_rdata_i(rd_bus), .bus_addr_o(addr_o),
    .bus_we_o(we_o), .bus_wdata_o(wdata_o), .demo_en_o(demo_o), .halt_req_o(halt_o)
  );

  function automatic bit win_hit();
    return cfg[7] && addr >= 8'h78 && addr <= 8'h7F;
  endfunction

  // reference model of the bank
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) model[i] = 0;
    end else if (win_hit() && we) begin
      model[addr - 8'h78] = int'(wd);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string rtag);
    int exp_rd, exp_pins;
    exp_rd = win_hit() ? model[addr - 8'h78] : int'(rd_bus);
    chk({rtag, " read data"}, int'(rdata_o), exp_rd);
    chk({rtag, " write strobe"}, int'(we_o), int'(we && !win_hit()));
    chk("R9 write data", int'(wdata_o), int'(wd));
    chk("R8 demo enable", int'(demo_o), int'(cfg[4]));
    chk("R8 halt request", int'(halt_o), int'(cfg[3]));
    case (cfg[2:0])
      3'd0: exp_pins = int'(addr[6:0]);
      3'd1: exp_pins = int'(acc[6:0]);
      3'd2: exp_pins = int'(acc[7]);
      3'd3: exp_pins = int'(mptr[6:0]);
      3'd4: exp_pins = int'(pc[6:0]);
      3'd5: exp_pins = int'(ir[6:0]);
      3'd6: exp_pins = int'(ccr);
      default: exp_pins = int'(st);
    endcase
    chk(cfg[2:0] < 3 ? "R6 pin view" : "R7 pin view", int'(addr_o), exp_pins);
  endtask

  // one clock: drive at negedge, compare mid-low phase
  task automatic step(input string rtag, input logic [7:0] c, input logic [7:0] a,
                      input logic w, input logic [7:0] d);
    @(negedge clk);
    cfg = c; addr = a; we = w; wd = d;
    rd_bus = 8'($urandom);
    acc = 8'($urandom); mptr = 8'($urandom); pc = 8'($urandom); ir = 8'($urandom);
    ccr = 2'($urandom); st = 7'($urandom);
    #1;
    compare(rtag);
  endtask

  initial begin
    // R1: reset contents
    for (int i = 0; i < 8; i++) step("R1", 8'h80, 8'h78 + 8'(i), 1'b0, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    // R3 fill, R2 readback
    for (int i = 0; i < 8; i++) step("R3", 8'h80, 8'h78 + 8'(i), 1'b1, 8'hA1 + 8'(i*17));
    for (int i = 7; i >= 0; i--) step("R2", 8'h80, 8'h78 + 8'(i), 1'b0, 8'h00);
    step("R3", 8'h80, 8'h7C, 1'b1, 8'h5A);
    step("R2", 8'h80, 8'h7C, 1'b0, 8'h00);
    // R4: disabled bank passes through, contents untouched
    step("R4", 8'h00, 8'h7A, 1'b1, 8'hEE);
    step("R4", 8'h00, 8'h7A, 1'b0, 8'h00);
    step("R4", 8'h00, 8'h7F, 1'b1, 8'h11);
    step("R4", 8'h80, 8'h7A, 1'b0, 8'h00);
    step("R4", 8'h80, 8'h7F, 1'b0, 8'h00);
    // R5: outside the window while enabled
    step("R5", 8'h80, 8'h77, 1'b1, 8'h33);
    step("R5", 8'h80, 8'hF8, 1'b1, 8'h44);
    step("R5", 8'h80, 8'hF8, 1'b0, 8'h00);
    step("R5", 8'h80, 8'h00, 1'b0, 8'h00);
    step("R5", 8'h80, 8'h78, 1'b0, 8'h00);
    // R6 R7 R8: every view code with varied upper config bits
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 8; s++)
        step("R8", {1'b1, 2'(r), 1'(r), 1'(s), 3'(s)}, 8'($urandom), 1'($urandom), 8'($urandom));
    // mixed traffic
    for (int k = 0; k < 200; k++)
      step("R2", 8'($urandom), 8'h70 + 8'($urandom_range(0, 20)), 1'($urandom), 8'($urandom));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule